// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers eight interrupt sources into six request lines and holds each request in a request register. A request is set by a rising edge on its line. A mask register selects requests one by one, and a global enable bit controls all of them together. A priority register, which software can write, holds an ordering of the six request indices. The highest-ranked request that is pending and unmasked is offered to the processor core as a grant. The grant carries the request index and the address of that request's entry in the vector table.

The core accepts the grant with an acknowledge. In that cycle the block clears the granted request bit and drops the global enable. Software must then turn the enable on again before another grant can appear. The request register keeps latching edges while requests are masked. A program can therefore poll it without using grants at all. Pushing the program counter and the flags is left to the core.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the request register reads 0, the mask register (all six enables and the global enable) reads 0, the priority register reads the identity ordering (slot k holds index k), and `irq_valid_o` is low.
- R2: A request bit is set only by a 0-to-1 change on its line. A line that stays high does not set the bit again after software has cleared it.
- R3: Lines 0 to 2 come from pins 0 to 2. Line 3 is pin 3 OR serial receive. Line 4 is serial transmit OR timer 0. Line 5 is timer 1.
- R4: The request register latches edges whatever the mask holds. A read at address 0 returns it in bits 5:0.
- R5: `irq_valid_o` is high exactly when the global enable (mask register bit 6) is set and at least one request is both pending and enabled by its mask bit (bits 5:0).
- R6: The priority register at address 2 holds six 3-bit slots, slot k in bits 3k+2:3k, with slot 0 the highest rank. The granted index is the index in the lowest slot whose request is pending and enabled.
- R7: `irq_vec_o` equals 2 × `irq_idx_o`. This is the first byte of the 16-bit vector for that request in a 12-byte table starting at address 0.
- R8: When `irq_valid_o` and `irq_ack_i` are both high at a clock edge, the granted request bit and the global enable are cleared. Clearing the enable takes priority over a mask write in the same cycle.
- R9: A write to address 0 clears each request bit written as 0 and leaves bits written as 1 unchanged. An edge arriving in the same cycle still sets its bit.
- R10: A priority slot that holds 6 or 7 is skipped by the encoder. Addresses 1 and 2 read back what was written, and address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_pin_i | input | 4 | External pin requests |
| src_rx_i | input | 1 | Serial receive done |
| src_tx_i | input | 1 | Serial transmit done |
| src_tmr_i | input | 2 | Timer 0 and timer 1 end of count |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 request, 1 mask, 2 priority |
| reg_wdata_i | input | 18 | Write data |
| reg_rdata_o | output | 18 | Read data for `reg_addr_i` |
| irq_valid_o | output | 1 | Grant offered |
| irq_idx_o | output | 3 | Granted request index |
| irq_vec_o | output | 16 | Vector table byte address |
| irq_ack_i | input | 1 | Core accepts the grant |

## Verification
The bench builds the block with its defaults: six requests, 3-bit priority slots, a vector stride of 2 and a base of 0. With these values every ordering, including slots that hold the unused codes 6 and 7, can be written directly. The full vector table can be checked against the index. A long pseudo-random phase then mixes source edges, acknowledges and writes. This reaches the cases where an acknowledge meets a new edge or a mask write in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_REQ  = 6;
  localparam int N_PIN  = 4;
  localparam int N_TMR  = 2;
  localparam int IDX_W  = $clog2(N_REQ);
  localparam int PRIO_W = N_REQ * IDX_W;
  localparam int MASK_W = N_REQ + 1;
  localparam int DATA_W = PRIO_W;
  localparam int VEC_W  = 16;

  typedef enum logic [1:0] {
    A_REQ  = 2'd0,
    A_MASK = 2'd1,
    A_PRIO = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIN-1:0] pin_i,
  input  logic             rx_i,
  input  logic             tx_i,
  input  logic [N_TMR-1:0] tmr_i,
  output logic [N_REQ-1:0] rise_o
);
  logic [N_REQ-1:0] line, prev_q;

  assign line = {tmr_i[1], tx_i | tmr_i[0], pin_i[3] | rx_i, pin_i[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= line;
  end

  assign rise_o = line & ~prev_q;

  p_rise_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_REQ-1:0]  rise_i,
  input  logic              ack_fire_i,
  input  logic [IDX_W-1:0]  ack_idx_i,
  output logic [N_REQ-1:0]  req_o,
  output logic [N_REQ-1:0]  mask_o,
  output logic              gen_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N_REQ-1:0] req_q, mask_q, keep, ack_clr;
  logic             gen_q;
  logic [PRIO_W-1:0] prio_q;
  logic wr_req, wr_mask, wr_prio;

  assign wr_req  = we_i && (addr_i == A_REQ);
  assign wr_mask = we_i && (addr_i == A_MASK);
  assign wr_prio = we_i && (addr_i == A_PRIO);
  assign keep    = wr_req ? wdata_i[N_REQ-1:0] : '1;
  assign ack_clr = ack_fire_i ? (N_REQ'(1) << ack_idx_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= (req_q & keep & ~ack_clr) | rise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gen_q  <= 1'b0;
    end else begin
      if (wr_mask) begin
        mask_q <= wdata_i[N_REQ-1:0];
        gen_q  <= wdata_i[N_REQ];
      end
      if (ack_fire_i) gen_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_REQ; k++) prio_q[k*IDX_W +: IDX_W] <= IDX_W'(k);
    end else if (wr_prio) begin
      prio_q <= wdata_i[PRIO_W-1:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_REQ:   rdata_o = DATA_W'(req_q);
      A_MASK:  rdata_o = DATA_W'({gen_q, mask_q});
      A_PRIO:  rdata_o = DATA_W'(prio_q);
      default: rdata_o = '0;
    endcase
  end

  assign req_o  = req_q;
  assign mask_o = mask_q;
  assign gen_o  = gen_q;
  assign prio_o = prio_q;

  p_edge_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> ((req_q & $past(rise_i)) == $past(rise_i)));
  p_ack_drops_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire_i |=> !gen_q);
  p_ack_clears_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire_i && ((rise_i & ack_clr) == '0)) |=> ((req_q & $past(ack_clr)) == '0));
  p_sw_no_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req |=> ((req_q & ~$past(req_q) & ~$past(rise_i)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [N_REQ-1:0]  elig_i,
  input  logic              gen_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [N_REQ-1:0] slot_hit;
  logic             found;

  for (genvar k = 0; k < N_REQ; k++) begin : g_slot
    logic [IDX_W-1:0] ent;
    assign ent         = prio_i[k*IDX_W +: IDX_W];
    assign slot_hit[k] = (int'(ent) < N_REQ) && elig_i[ent];
  end

  always_comb begin
    found = 1'b0;
    idx_o = '0;
    for (int k = N_REQ - 1; k >= 0; k--) begin
      if (slot_hit[k]) begin
        found = 1'b1;
        idx_o = prio_i[k*IDX_W +: IDX_W];
      end
    end
  end

  assign valid_o = gen_i && found;

  p_winner_eligible_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> elig_i[idx_o]);
  p_idx_in_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(idx_o) < N_REQ));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_STRIDE = 2,
  parameter int VEC_BASE   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PIN-1:0]  src_pin_i,
  input  logic              src_rx_i,
  input  logic              src_tx_i,
  input  logic [N_TMR-1:0]  src_tmr_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_valid_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  input  logic              irq_ack_i
);
  logic [N_REQ-1:0]  rise, req, mask;
  logic              gen, ack_fire;
  logic [PRIO_W-1:0] prio;

  irq_src_map u_map (
    .clk_i, .rst_ni,
    .pin_i (src_pin_i), .rx_i (src_rx_i), .tx_i (src_tx_i), .tmr_i (src_tmr_i),
    .rise_o(rise)
  );

  irq_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rise_i(rise), .ack_fire_i(ack_fire), .ack_idx_i(irq_idx_o),
    .req_o(req), .mask_o(mask), .gen_o(gen), .prio_o(prio),
    .rdata_o(reg_rdata_o)
  );

  irq_prio_enc u_enc (
    .clk_i, .rst_ni,
    .prio_i(prio), .elig_i(req & mask), .gen_i(gen),
    .valid_o(irq_valid_o), .idx_o(irq_idx_o)
  );

  assign ack_fire  = irq_valid_o && irq_ack_i;
  assign irq_vec_o = VEC_W'(VEC_BASE + VEC_STRIDE * int'(irq_idx_o));

  p_grant_cond_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (gen && ((req & mask) != '0)));
  p_grant_off_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !(reg_we_i && reg_addr_i == A_MASK)) |=> !irq_valid_o);
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  import irq_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] pin = '0;
  logic rx = 0, tx = 0, ack = 0, we = 0;
  logic [1:0] tmr = '0, addr = '0;
  logic [17:0] wdata = '0, rdata;
  logic valid;
  logic [2:0] idx;
  logic [15:0] vec;
  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_pin_i(pin), .src_rx_i(rx), .src_tx_i(tx),
    .src_tmr_i(tmr), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_valid_o(valid), .irq_idx_o(idx), .irq_vec_o(vec),
    .irq_ack_i(ack)
  );

  // reference model
  bit [5:0] m_req, m_mask, m_prev;
  bit m_gen;
  int m_prio[6];

  function automatic int m_win();
    for (int k = 0; k < 6; k++)
      if (m_prio[k] < 6 && m_req[m_prio[k]] && m_mask[m_prio[k]]) return m_prio[k];
    return -1;
  endfunction

  function automatic int m_read(int a);
    int v = 0;
    case (a)
      0: v = m_req;
      1: v = {m_gen, m_mask};
      2: for (int k = 0; k < 6; k++) v += m_prio[k] << (3 * k);
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit [5:0] ln, rs, nreq;
    int w;
    if (!rst_n) begin
      m_req = 0; m_mask = 0; m_gen = 0; m_prev = 0;
      for (int k = 0; k < 6; k++) m_prio[k] = k;
    end else begin
      ln = {tmr[1], tx | tmr[0], pin[3] | rx, pin[2:0]};
      rs = ln & ~m_prev;
      m_prev = ln;
      w = m_gen ? m_win() : -1;
      nreq = m_req;
      if (we && addr == 0) nreq &= wdata[5:0];
      if (w >= 0 && ack) nreq[w] = 0;
      nreq |= rs;
      m_req = nreq;
      if (we && addr == 1) begin m_mask = wdata[5:0]; m_gen = wdata[6]; end
      if (w >= 0 && ack) m_gen = 0;
      if (we && addr == 2) for (int k = 0; k < 6; k++) m_prio[k] = wdata[3*k +: 3];
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int w = m_gen ? m_win() : -1;
    chk(valid == (w >= 0), "R5", valid, w >= 0);
    if (w >= 0) begin
      chk(idx == w, "R6", idx, w);
      chk(vec == 2 * w, "R7", vec, 2 * w);
    end
    chk(rdata == m_read(addr), cur_tag, rdata, m_read(addr));
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk); compare(); end
  endtask

  task automatic wr(int a, int d);
    we = 1; addr = a[1:0]; wdata = d[17:0]; cyc(); we = 0;
  endtask

  task automatic rd(int a);
    addr = a[1:0]; cyc();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int unsigned r = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset contents
    cur_tag = "R1"; rd(0); rd(1); rd(2); rd(3);
    chk(rdata == 0 && !valid, "R1", rdata, 0);
    // R4: masked edge still latches, no grant
    cur_tag = "R4"; pin[0] = 1; rd(0); rd(0);
    chk(rdata[0] == 1 && !valid, "R4", rdata, 1);
    // R2: held line does not re-latch after clear
    cur_tag = "R2"; wr(0, 0); rd(0); cyc(3);
    chk(rdata[0] == 0, "R2", rdata, 0);
    pin[0] = 0; cyc();
    // R3: source mapping
    cur_tag = "R3";
    rx = 1; cyc(); chk(rdata[3] == 1, "R3", rdata, 8); rx = 0; wr(0, 0);
    tx = 1; rd(0); chk(rdata[4] == 1, "R3", rdata, 16); tx = 0; wr(0, 0);
    tmr[0] = 1; rd(0); chk(rdata == 16, "R3", rdata, 16); tmr[0] = 0; wr(0, 0);
    tmr[1] = 1; rd(0); chk(rdata == 32, "R3", rdata, 32); tmr[1] = 0; wr(0, 0);
    pin = 4'hF; rd(0); chk(rdata == 15, "R3", rdata, 15); pin = 0; wr(0, 0);
    // R5: enables
    cur_tag = "R5"; pin = 4'b0110; rx = 0; cyc(); pin = 0;
    wr(1, 6'h3F); rd(1); chk(!valid, "R5", valid, 0);
    wr(1, 7'h40); chk(!valid, "R5", valid, 0);
    wr(1, 7'h44); chk(valid && idx == 2, "R5", idx, 2);
    // R6: programmed orderings
    cur_tag = "R6"; wr(1, 7'h7F);
    wr(2, (1 << 0) | (2 << 3) | (0 << 6) | (3 << 9) | (4 << 12) | (5 << 15));
    chk(idx == 1, "R6", idx, 1);
    wr(2, (2 << 0) | (1 << 3) | (0 << 6) | (3 << 9) | (4 << 12) | (5 << 15));
    chk(idx == 2 && vec == 4, "R7", vec, 4);
    // R10: unused codes skipped
    cur_tag = "R10"; wr(2, (7 << 0) | (6 << 3) | (1 << 6) | (2 << 9) | (0 << 12) | (5 << 15));
    rd(2); chk(idx == 1, "R10", idx, 1);
    wr(3, 18'h3FFFF); rd(3); chk(rdata == 0, "R10", rdata, 0);
    // R8: acknowledge
    cur_tag = "R8"; ack = 1; addr = 1; cyc(); ack = 0; cyc();
    chk(!valid && rdata == 7'h3F, "R8", rdata, 7'h3F);
    rd(0); chk(rdata == 6'b000100, "R8", rdata, 4);
    // ack and mask write in same cycle: ack wins
    wr(1, 7'h7F); ack = 1; wr(1, 7'h7F); ack = 0; rd(1);
    chk(rdata == 7'h3F, "R8", rdata, 7'h3F);
    // R9: write ones keeps, edge in write cycle sets
    cur_tag = "R9"; pin[1] = 1; cyc(); pin[1] = 0;
    pin[0] = 1; wr(0, 0); pin[0] = 0; rd(0);
    chk(rdata == 1, "R9", rdata, 1);
    pin[3] = 1; cyc(); pin[3] = 0; wr(0, 6'h3E); rd(0);
    chk(rdata == 8, "R9", rdata, 8);
    // mixed pseudo-random phase
    cur_tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      r = r * 1103515245 + 12345;
      pin = r[27:24]; rx = r[28]; tx = r[29]; tmr = r[31:30];
      ack = r[10];
      addr = r[13:12];
      we = (r[17:14] == 0);
      wdata = {r[9:0], r[23:16]} ^ 18'h00040;
      cyc();
      we = 0;
      if (r[21:18] == 1) wr(1, {1'b1, r[5:0]});
    end
    we = 0; ack = 0;
    cyc(2);
    summary();
  end
endmodule